// File: doc/BRIEF.md
# Dual-Wiper Potentiometer Command Slave on I2C

This block is an I2C target that owns the register state of a two-channel digital potentiometer. It runs on the system clock and oversamples the bus. It responds only to a control byte that carries its fixed device code and the value on three strap pins. It then decodes packed command bytes. Each command byte selects one wiper, names an operation and may carry the top data bit.

A host can load a wiper with a 9-bit value, step a wiper up or down by one count, or read a wiper back. A read uses a repeated Start: first a write-mode control byte and a read command, then a read-mode control byte. The slave keeps the last accepted memory address, so later reads can skip the command phase, even after a Stop. Both wiper values are driven out continuously to the analog side.

Top module: `dpot_i2c_slave`

## Requirements
- R1: A control byte whose bits 7:4 equal 0101 and whose bits 3:1 equal `strap_i` is acknowledged, and bit 0 selects the direction (0 = write, 1 = read). Any other control byte is not acknowledged, and every later byte is ignored until the next Start.
- R2: A command byte carries the memory address in bits 7:4, the operation in bits 3:2 (00 load, 01 step up, 10 step down, 11 read) and data bits 9:8 in bits 1:0. Only addresses 0 and 1 exist. A command to any other address is not acknowledged, changes no wiper and makes the slave ignore the bus until the next Start.
- R3: A load takes bit 8 from command bit 0 and bits 7:0 from the next byte, which is acknowledged. The wiper is updated when that byte has been received. Values above 0x100 are stored as 0x100, and data bit 9 has no effect.
- R4: A step-up command is a single acknowledged byte. It adds one to the addressed wiper and holds it at 0x100 once it is there.
- R5: A step-down command is a single acknowledged byte. It subtracts one from the addressed wiper and holds it at 0 once it is there.
- R6: After a read-mode control byte, the slave returns the wiper at the stored address as two bytes, MSB first: first {7'b0, bit 8}, then bits 7:0. While the host keeps acknowledging, the slave keeps returning these two bytes in turn.
- R7: When the host does not acknowledge a returned byte, the slave stops driving SDA and stays off the bus until the next Start or Stop.
- R8: The stored address changes only when a command byte is acknowledged. It survives Stop and repeated Start, so a read-mode control byte sent after a Stop returns the same wiper.
- R9: SCL and SDA pass through two flip-flop stages. Start is SDA falling while SCL is high, and Stop is SDA rising while SCL is high. The slave changes its SDA drive only while SCL is low.
- R10: After reset, both wipers are 0x080, the stored address is 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL level seen on the pin |
| sda_i | input | 1 | SDA level seen on the pin |
| strap_i | input | 3 | Address strap pins compared with control byte bits 3:1 |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain drive) |
| wiper0_o | output | 9 | Value of wiper 0 |
| wiper1_o | output | 9 | Value of wiper 1 |

## Verification
The assertions check the following on every clock: the SDA drive changes only in the low phase of the synchronised SCL, and wipers never exceed full scale. They also check that single steps move by exactly one count and stop at the ends. A rejected control or command byte leaves SDA released. The stored address stays fixed unless a command byte is accepted, and a host NACK on a returned byte drops the slave off the bus. Only the bench's transactions can show that the right bytes are acknowledged and that read data comes back in the right byte order. They also show that the address survives a Stop, and that traffic after a rejected byte is really ignored. The bench's behavioural model tracks the wiper outputs on every clock throughout.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int NUM_WIPERS = 2;
  localparam int ADDR_W     = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_TX_NEXT
  } bus_st_e;

  typedef enum logic [1:0] {
    PH_CTRL, PH_CMD, PH_DATA
  } rx_ph_e;

  typedef enum logic [1:0] {
    OP_LOAD = 2'b00,
    OP_UP   = 2'b01,
    OP_DOWN = 2'b10,
    OP_READ = 2'b11
  } op_e;
endpackage

// File: rtl/dpot_bus_sync.sv
module dpot_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_o      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = !scl_d && scl_o;
  assign scl_fall_o = scl_d && !scl_o;
  // SDA edges count only while SCL stayed high across the sample
  assign start_o    = scl_d && scl_o && sda_d && !sda_o;
  assign stop_o     = scl_d && scl_o && !sda_d && sda_o;
endmodule

// File: rtl/dpot_wiper_bank.sv
module dpot_wiper_bank #(
  parameter int N      = 2,
  parameter int W      = 9,
  parameter int ADDR_W = 4,
  parameter int RST    = 128
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic                  inc_i,
  input  logic                  dec_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [W-1:0]          wdata_i,
  output logic [N-1:0][W-1:0]   wiper_o
);
  localparam logic [W-1:0] FULL = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] RSTV = W'(RST);

  for (genvar g = 0; g < N; g++) begin : g_wiper
    logic sel;
    assign sel = (addr_i == ADDR_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wiper_o[g] <= RSTV;
      end else if (we_i && sel) begin
        wiper_o[g] <= (wdata_i > FULL) ? FULL : wdata_i;
      end else if (inc_i && sel && wiper_o[g] < FULL) begin
        wiper_o[g] <= wiper_o[g] + 1'b1;
      end else if (dec_i && sel && wiper_o[g] != '0) begin
        wiper_o[g] <= wiper_o[g] - 1'b1;
      end
    end

    p_wiper_cap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wiper_o[g] <= FULL);
    p_up_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_i && sel && wiper_o[g] < FULL) |=> wiper_o[g] == $past(wiper_o[g]) + 1'b1);
    p_up_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_i && sel && wiper_o[g] == FULL) |=> wiper_o[g] == FULL);
    p_down_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_i && sel && wiper_o[g] != '0) |=> wiper_o[g] == $past(wiper_o[g]) - 1'b1);
    p_down_floor_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_i && sel && wiper_o[g] == '0) |=> wiper_o[g] == '0);
  end
endmodule

// File: rtl/dpot_i2c_slave.sv
module dpot_i2c_slave
  import dpot_pkg::*;
#(
  parameter logic [3:0] DEV_CODE    = 4'b0101,
  parameter int         WIPER_W     = 9,
  parameter int         WIPER_RST   = 128,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [2:0]         strap_i,
  output logic               sda_oe_o,
  output logic [WIPER_W-1:0] wiper0_o,
  output logic [WIPER_W-1:0] wiper1_o
);
  localparam int IW = (NUM_WIPERS > 1) ? $clog2(NUM_WIPERS) : 1;

  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  dpot_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(bus_start), .stop_o(bus_stop)
  );

  bus_st_e           st_q;
  rx_ph_e            ph_q;
  logic [3:0]        bit_cnt_q;
  logic [7:0]        rx_sh_q, tx_sh_q;
  logic              d8_q, tx_go_q, tx_lo_q;
  logic [ADDR_W-1:0] ptr_q;

  logic [NUM_WIPERS-1:0][WIPER_W-1:0] wipers;
  logic [WIPER_W-1:0] cur_w;
  logic [7:0]         hi_byte, lo_byte, next_byte;

  logic              byte_done, ctrl_ok, addr_ok;
  logic [ADDR_W-1:0] b_addr, bank_addr;
  op_e               b_op;
  logic              we, inc, dec;

  assign byte_done = scl_fall && st_q == ST_RX && bit_cnt_q == 4'd8;
  assign b_addr    = rx_sh_q[7:4];
  assign b_op      = op_e'(rx_sh_q[3:2]);
  assign addr_ok   = b_addr < ADDR_W'(NUM_WIPERS);
  assign ctrl_ok   = rx_sh_q[7:4] == DEV_CODE && rx_sh_q[3:1] == strap_i;

  assign we  = byte_done && ph_q == PH_DATA;
  assign inc = byte_done && ph_q == PH_CMD && addr_ok && b_op == OP_UP;
  assign dec = byte_done && ph_q == PH_CMD && addr_ok && b_op == OP_DOWN;
  assign bank_addr = (ph_q == PH_DATA) ? ptr_q : b_addr;

  dpot_wiper_bank #(
    .N(NUM_WIPERS), .W(WIPER_W), .ADDR_W(ADDR_W), .RST(WIPER_RST)
  ) u_bank (
    .clk_i, .rst_ni,
    .we_i(we), .inc_i(inc), .dec_i(dec),
    .addr_i(bank_addr),
    .wdata_i(WIPER_W'({d8_q, rx_sh_q})),
    .wiper_o(wipers)
  );

  assign cur_w     = wipers[ptr_q[IW-1:0]];
  assign hi_byte   = 8'(cur_w >> 8);
  assign lo_byte   = cur_w[7:0];
  assign next_byte = tx_lo_q ? lo_byte : hi_byte;
  assign wiper0_o  = wipers[0];
  assign wiper1_o  = wipers[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ph_q      <= PH_CTRL;
      bit_cnt_q <= '0;
      rx_sh_q   <= '0;
      tx_sh_q   <= '0;
      d8_q      <= 1'b0;
      tx_go_q   <= 1'b0;
      tx_lo_q   <= 1'b0;
      ptr_q     <= '0;
      sda_oe_o  <= 1'b0;
    end else if (bus_start) begin
      st_q      <= ST_RX;
      ph_q      <= PH_CTRL;
      bit_cnt_q <= '0;
      sda_oe_o  <= 1'b0;
    end else if (bus_stop) begin
      st_q     <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise && bit_cnt_q < 4'd8) begin
            rx_sh_q   <= {rx_sh_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (byte_done) begin
            bit_cnt_q <= '0;
            tx_go_q   <= 1'b0;
            case (ph_q)
              PH_CTRL: begin
                if (ctrl_ok) begin
                  sda_oe_o <= 1'b1;
                  tx_go_q  <= rx_sh_q[0];
                  ph_q     <= PH_CMD;
                  st_q     <= ST_RX_ACK;
                end else begin
                  st_q <= ST_IDLE;
                end
              end
              PH_CMD: begin
                if (addr_ok) begin
                  sda_oe_o <= 1'b1;
                  ptr_q    <= b_addr;
                  d8_q     <= rx_sh_q[0];
                  ph_q     <= (b_op == OP_LOAD) ? PH_DATA : PH_CMD;
                  st_q     <= ST_RX_ACK;
                end else begin
                  st_q <= ST_IDLE;
                end
              end
              PH_DATA: begin
                sda_oe_o <= 1'b1;
                ph_q     <= PH_CMD;
                st_q     <= ST_RX_ACK;
              end
              default: st_q <= ST_IDLE;
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            bit_cnt_q <= '0;
            if (tx_go_q) begin
              tx_sh_q  <= hi_byte;
              sda_oe_o <= !hi_byte[7];
              tx_lo_q  <= 1'b1;
              st_q     <= ST_TX;
            end else begin
              sda_oe_o <= 1'b0;
              st_q     <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt_q == 4'd7) begin
              sda_oe_o <= 1'b0;
              st_q     <= ST_TX_ACK;
            end else begin
              tx_sh_q   <= {tx_sh_q[6:0], 1'b0};
              sda_oe_o  <= !tx_sh_q[6];
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) st_q <= sda_s ? ST_IDLE : ST_TX_NEXT;
        end
        ST_TX_NEXT: begin
          if (scl_fall) begin
            tx_sh_q   <= next_byte;
            sda_oe_o  <= !next_byte[7];
            tx_lo_q   <= !tx_lo_q;
            bit_cnt_q <= '0;
            st_q      <= ST_TX;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_sda_low_phase_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s);
  p_ctrl_reject_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && ph_q == PH_CTRL && !ctrl_ok && !bus_start) |=> (!sda_oe_o && st_q == ST_IDLE));
  p_cmd_reject_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && ph_q == PH_CMD && !addr_ok && !bus_start) |=> (!sda_oe_o && st_q == ST_IDLE));
  p_one_action_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({u_bank.we_i, u_bank.inc_i, u_bank.dec_i}));
  p_host_nack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TX_ACK && scl_rise && sda_s && !bus_start && !bus_stop) |=> (st_q == ST_IDLE && !sda_oe_o));
  p_ptr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byte_done && ph_q == PH_CMD && addr_ok) |=> $stable(ptr_q));
endmodule

// File: tb/dpot_i2c_slave_test.sv
`timescale 1ns/1ps
module dpot_i2c_slave_test;
  localparam int Q     = 8;
  localparam int TOL   = 64;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] CW = {4'b0101, STRAP, 1'b0};
  localparam logic [7:0] CR = {4'b0101, STRAP, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [8:0] w0, w1;
  wire sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0;
  int exp_w[2];
  int exp_ptr = 0;
  bit run = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dpot_i2c_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(STRAP), .sda_oe_o(sda_oe), .wiper0_o(w0), .wiper1_o(w1)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // per-clock comparison of wiper outputs against the model
  int streak = 0;
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (run) begin
      n_chk++;
      if (int'(w0) != exp_w[0] || int'(w1) != exp_w[1]) begin
        streak++;
        if (streak == TOL) begin
          n_fail++;
          $display("FAIL R3/R4/R5 model: actual 0x%0h/0x%0h expected 0x%0h/0x%0h",
                   w0, w1, exp_w[0], exp_w[1]);
        end
      end else streak = 0;
      // R9: drive must change only while SCL is low
      if (sda_oe !== prev_oe) chk(scl_m == 1'b0, "R9 sda change with scl high", scl_m, 0);
      prev_oe = sda_oe;
    end
  end

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); sda_m = 1'b0; hq(); scl_m = 1'b0; hq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hq(); scl_m = 1'b1; hq(); sda_m = 1'b1; hq();
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hq(); scl_m = 1'b1; hq(); scl_m = 1'b0; hq();
    end
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq();
    ack = !sda_line;
    scl_m = 1'b0; hq();
  endtask

  task automatic recv(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hq(); scl_m = 1'b1; hq(); b[i] = sda_line; scl_m = 1'b0;
    end
    hq(); sda_m = !mack; hq(); scl_m = 1'b1; hq(); scl_m = 1'b0; hq(); sda_m = 1'b1;
  endtask

  function automatic int clamp(input int v);
    return (v > 256) ? 256 : v;
  endfunction

  task automatic load(input int addr, input int val);
    bit a;
    bit ok = addr < 2;
    bus_start();
    send(CW, a); chk(a == 1'b1, "R1 ctrl ack", a, 1);
    send({4'(addr), 2'b00, 1'b1, 1'(val >> 8)}, a);
    chk(a == ok, "R2 load cmd ack", a, ok);
    if (a) begin
      send(8'(val), a); chk(a == 1'b1, "R3 data ack", a, 1);
      exp_w[addr] = clamp(val & 9'h1ff);
      exp_ptr = addr;
    end
    bus_stop();
  endtask

  task automatic step(input int addr, input bit up);
    bit a;
    bit ok = addr < 2;
    bus_start();
    send(CW, a); chk(a == 1'b1, "R1 ctrl ack", a, 1);
    send({4'(addr), (up ? 2'b01 : 2'b10), 2'b00}, a);
    chk(a == ok, up ? "R4 up cmd ack" : "R5 down cmd ack", a, ok);
    if (ok) begin
      if (up) exp_w[addr] = (exp_w[addr] < 256) ? exp_w[addr] + 1 : 256;
      else    exp_w[addr] = (exp_w[addr] > 0) ? exp_w[addr] - 1 : 0;
      exp_ptr = addr;
    end
    bus_stop();
  endtask

  task automatic read_sr(input int addr);
    bit a;
    logic [7:0] hi, lo;
    bus_start();
    send(CW, a); chk(a == 1'b1, "R1 ctrl ack", a, 1);
    send({4'(addr), 2'b11, 2'b00}, a); chk(a == (addr < 2), "R2 read cmd ack", a, addr < 2);
    if (a) exp_ptr = addr;
    bus_start();
    send(CR, a); chk(a == 1'b1, "R6 read ctrl ack", a, 1);
    recv(1'b1, hi); recv(1'b0, lo);
    chk(int'(hi) == (exp_w[exp_ptr] >> 8), "R6 high byte", hi, exp_w[exp_ptr] >> 8);
    chk(int'(lo) == (exp_w[exp_ptr] & 8'hff), "R6 low byte", lo, exp_w[exp_ptr] & 8'hff);
    bus_stop();
  endtask

  task automatic read_direct(input string req);
    bit a;
    logic [7:0] hi, lo;
    bus_start();
    send(CR, a); chk(a == 1'b1, req, a, 1);
    recv(1'b1, hi); recv(1'b0, lo);
    chk(int'({hi[0], lo}) == exp_w[exp_ptr] && hi[7:1] == 7'd0, req, {hi, lo}, exp_w[exp_ptr]);
    bus_stop();
  endtask

  initial begin
    bit a;
    logic [7:0] b0, b1, b2;
    int lows;
    exp_w[0] = 128; exp_w[1] = 128;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(w0 == 9'h080, "R10 reset wiper0", w0, 128);
    chk(w1 == 9'h080, "R10 reset wiper1", w1, 128);
    chk(sda_oe == 1'b0, "R10 reset sda released", sda_oe, 0);
    run = 1'b1;
    read_direct("R10 reset pointer reads wiper0");

    load(0, 9'h0AB);
    chk(w0 == 9'h0AB, "R3 load wiper0", w0, 9'h0AB);
    load(1, 9'h1FF);
    chk(w1 == 9'h100, "R3 clamp to full scale", w1, 9'h100);
    step(1, 1'b1);
    chk(w1 == 9'h100, "R4 hold at full scale", w1, 9'h100);
    step(0, 1'b1);
    chk(w0 == 9'h0AC, "R4 up by one", w0, 9'h0AC);
    step(0, 1'b0);
    chk(w0 == 9'h0AB, "R5 down by one", w0, 9'h0AB);
    load(0, 1);
    step(0, 1'b0); step(0, 1'b0);
    chk(w0 == 9'h000, "R5 hold at zero", w0, 0);
    step(1, 1'b0);
    chk(w1 == 9'h0FF, "R5 down across bit 8", w1, 9'h0FF);

    // R2: unimplemented addresses
    load(5, 9'h033);
    step(3, 1'b1);
    chk(w0 == 9'h000 && w1 == 9'h0FF, "R2 bad address no change", {w0, w1}, 9'h0FF);

    // R1: wrong strap, then wrong device code; later bytes ignored
    bus_start();
    send({4'b0101, STRAP ^ 3'b001, 1'b0}, a); chk(a == 1'b0, "R1 strap mismatch nack", a, 0);
    send({4'd0, 2'b00, 2'b01}, a); chk(a == 1'b0, "R1 ignored after mismatch", a, 0);
    send(8'h55, a); chk(a == 1'b0, "R1 ignored data", a, 0);
    bus_stop();
    bus_start();
    send({4'b0110, STRAP, 1'b0}, a); chk(a == 1'b0, "R1 code mismatch nack", a, 0);
    send({4'd1, 2'b01, 2'b00}, a); chk(a == 1'b0, "R1 ignored step", a, 0);
    bus_stop();
    chk(w0 == 9'h000 && w1 == 9'h0FF, "R1 wipers unchanged", {w0, w1}, 9'h0FF);

    load(1, 9'h100);
    read_sr(1);
    load(0, 9'h0A5);
    read_sr(0);

    // R8: pointer survives Stop and rejected commands
    step(1, 1'b1);
    read_direct("R8 pointer after stop");
    bus_start();
    send(CW, a);
    send({4'd7, 2'b11, 2'b00}, a); chk(a == 1'b0, "R2 read cmd bad address nack", a, 0);
    bus_stop();
    read_direct("R8 pointer kept after rejected command");

    // R7: host NACK releases the bus
    load(0, 9'h0A5);
    bus_start();
    send(CR, a);
    recv(1'b0, b0);
    chk(b0 == 8'h00, "R6 high byte before nack", b0, 0);
    lows = 0;
    sda_m = 1'b1;
    for (int i = 0; i < 9; i++) begin
      hq(); scl_m = 1'b1; hq(); if (!sda_line) lows++; scl_m = 1'b0;
    end
    hq();
    chk(lows == 0, "R7 released after host nack", lows, 0);
    bus_stop();

    // R6: continuous read alternates high and low bytes
    load(1, 9'h13C);
    bus_start();
    send(CR, a);
    recv(1'b1, b0); recv(1'b1, b1); recv(1'b0, b2);
    chk(b0 == 8'h01, "R6 stream high", b0, 1);
    chk(b1 == 8'h00, "R6 stream low", b1, 0);
    chk(b2 == b0, "R6 stream repeats high", b2, b0);
    bus_stop();

    // R3: data bit 9 has no effect
    bus_start();
    send(CW, a);
    send({4'd0, 2'b00, 2'b10}, a);
    send(8'h3C, a); chk(a == 1'b1, "R3 data ack with bit 9", a, 1);
    exp_w[0] = 9'h03C; exp_ptr = 0;
    bus_stop();
    chk(w0 == 9'h03C, "R3 bit 9 ignored", w0, 9'h03C);

    repeat (TOL + 4) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule